// File: doc/BRIEF.md
# Two-Channel Modulo Timer with Linked PWM

This block is a free-running up-counter with a programmable period and two channels. The counter advances once per cycle in which the tick enable is high. It returns to zero on the tick after it reaches the modulo value. Each channel works either as an edge-triggered capture of the count or as a compare output. In compare mode the output is set at the start of each period and cleared when the count reaches the channel value, which gives a pulse-width output. Two control bits turn that output into a true 0% or 100% duty.

A link bit in channel 0's control register joins both channels into one buffered PWM on channel 0's pin. The compare value alternates between the two channels' value registers. A new duty value goes into the register that is not in use, and it takes over at the next period boundary, so a period is never cut short or stretched by a write.

Software clears flags with a read-then-write sequence. Interrupt requests are the flags gated by their enables. A break input halts the counter and blocks captures. A stop input freezes all state. Wait-type standby needs no input of its own, because the timer runs whenever stop is low.

Top module: `pair_timer`

Register addresses: 0 status (bit 7 overflow flag, bit 6 overflow enable), 1 count (read only), 2 modulo, 3 channel 0 control, 4 channel 0 value, 5 channel 1 control, 6 channel 1 value. The bits of a control register are: 7 flag, 6 interrupt enable, 5 link (channel 0 only), 4 compare mode (0 = capture), 3 capture on rising edge (0 = falling), 2 set-on-overflow, 1 full duty.

## Requirements
- R1: After reset the count and both value registers are 0, the modulo is all ones, every control bit and flag is 0, and both pins and all interrupt requests are low.
- R2: Each enabled tick raises the count by one. A tick taken at the modulo value returns the count to 0 and sets status bit 7.
- R3: irq_ovf is high exactly when status bits 7 and 6 are both set. irq_ch[i] is high exactly when bits 7 and 6 of channel i's control register are both set.
- R4: In compare mode with set-on-overflow, the pin goes high at each wrap and low on the tick that brings the count to the value. Over one period this gives value high cycles, 0 cycles for value 0, and modulo+1 cycles when the value exceeds the modulo.
- R5: With set-on-overflow clear, a compare output that is low stays low, which gives a constant 0% duty.
- R6: With full duty and set-on-overflow both set, the compare output is held high, which gives a 100% duty.
- R7: In capture mode, the selected edge on the channel's input loads the current count into its value register and sets the channel flag. The other edge does nothing.
- R8: A flag clears only when a read of its register while it is set is followed by a write with bit 7 at 0. A write without the arming read leaves the flag set. A flag event in the same cycle as the clearing write keeps the flag set.
- R9: While brk is high the count holds and captures are ignored. Flags can be cleared during break only when brk_clr_ok is high.
- R10: While stop_mode is high the count, the registers and the flags hold, and writes are ignored.
- R11: With the link bit set, channel 0's pin carries the PWM whatever the compare-mode bit says. Channel 0's set-on-overflow and full-duty bits govern it, channel 0's value register is used first, and pin_out[1] stays low.
- R12: In linked mode, a write to the value register not in use takes effect at the next wrap, and from then on that register sets the duty. The period in which the write lands keeps its old duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| addr | input | 3 | Register address |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data (combinational) |
| pin_in | input | 2 | Capture inputs, one per channel |
| pin_out | output | 2 | Compare/PWM outputs |
| brk | input | 1 | Break: halt counter, block captures |
| brk_clr_ok | input | 1 | Allow flag clearing during break |
| stop_mode | input | 1 | Freeze all timer state |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_ch | output | 2 | Channel interrupt requests |

## Verification
The bench builds the block with CNT_W = 8, so the reset modulo of all ones is a 256-cycle period and short periods of five or ten cycles cover every duty corner in a few dozen cycles. The table walks the duty cases: zero value, value above the modulo, set-on-overflow cleared, and full duty. Directed tests then line up a flag event with a clearing write, and send a capture edge and a clearing write during break. A duty write in the middle of a period is timed against the observed rising edge of the linked output.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;
  localparam logic [2:0] A_STAT  = 3'd0;
  localparam logic [2:0] A_COUNT = 3'd1;
  localparam logic [2:0] A_MOD   = 3'd2;
  localparam logic [2:0] A_C0CTL = 3'd3;
  localparam logic [2:0] A_C0VAL = 3'd4;
  localparam logic [2:0] A_C1CTL = 3'd5;
  localparam logic [2:0] A_C1VAL = 3'd6;

  localparam int unsigned N_CH   = 2;
  localparam int unsigned N_FLAG = N_CH + 1;

  // packed into control bits [6:1]
  typedef struct packed {
    logic ie;
    logic link;
    logic cmp;
    logic rise;
    logic tov;
    logic maxd;
  } chctl_t;

  function automatic logic [2:0] flag_addr(input int unsigned idx);
    case (idx)
      0:       return A_STAT;
      1:       return A_C0CTL;
      default: return A_C1CTL;
    endcase
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             wrap
);
  always_comb begin
    cnt_nxt = (count == modulo) ? '0 : count + 1'b1;
    wrap    = adv && (count == modulo);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (adv) count <= cnt_nxt;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (count == '0)); // R2
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(count)); // R9
endmodule

// File: rtl/tmr_flag.sv
module tmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_ev,
  input  logic rd_hit,
  input  logic wr_hit,
  input  logic wr_bit,
  input  logic clr_ok,
  output logic flag
);
  logic arm_q, arm_n, flag_n;

  always_comb begin
    arm_n = arm_q;
    if (rd_hit && flag) arm_n = 1'b1;
    else if (wr_hit)    arm_n = 1'b0;
    flag_n = flag;
    if (set_ev)                                    flag_n = 1'b1;
    else if (wr_hit && !wr_bit && arm_q && clr_ok) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      flag  <= 1'b0;
    end else begin
      arm_q <= arm_n;
      flag  <= flag_n;
    end
  end

  AST_EVENT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> flag); // R8
  AST_NO_BLIND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !arm_q) |=> flag); // R8
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             wrap,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             out_en,
  input  logic             tov,
  input  logic             maxd,
  input  logic             cap_en,
  input  logic             rise,
  input  logic             pin,
  output logic             pin_out,
  output logic             match_ev,
  output logic             cap_ev
);
  logic pin_q, edge_seen, out_n;

  always_comb begin
    match_ev  = adv && out_en && (cnt_nxt == cmp_val);
    edge_seen = rise ? (pin && !pin_q) : (!pin && pin_q);
    cap_ev    = cap_en && edge_seen;
    out_n     = pin_out;
    if (!out_en)           out_n = 1'b0;
    else if (maxd && tov)  out_n = 1'b1;
    else if (match_ev)     out_n = 1'b0;
    else if (wrap && tov)  out_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      pin_out <= 1'b0;
    end else begin
      pin_q   <= pin;
      pin_out <= out_n;
    end
  end

  AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && maxd && tov) |=> pin_out); // R6
  AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en && !tov && !pin_out) |=> !pin_out); // R5
endmodule

// File: rtl/pair_timer.sv
module pair_timer
  import ptmr_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [2:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic [1:0]       pin_in,
  output logic [1:0]       pin_out,
  input  logic             brk,
  input  logic             brk_clr_ok,
  input  logic             stop_mode,
  output logic             irq_ovf,
  output logic [1:0]       irq_ch
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rs_q;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_s = rs_q[1];

  logic live, adv, cap_ok, clr_ok, wr_ok, rd_ok, link;
  always_comb begin
    live   = !stop_mode;
    adv    = tick_en && live && !brk;
    cap_ok = live && !brk;
    clr_ok = live && (!brk || brk_clr_ok);
    wr_ok  = wr_en && live;
    rd_ok  = rd_en && live;
  end

  logic             ovf_ie_q, ovf_ie_n;
  chctl_t           ctl_q [N_CH];
  chctl_t           ctl_n [N_CH];
  logic [CNT_W-1:0] val_q [N_CH];
  logic [CNT_W-1:0] val_n [N_CH];
  logic [CNT_W-1:0] mod_q, mod_n;
  logic             sel_q, sel_n, pend_q, pend_n;

  logic [CNT_W-1:0] count, cnt_nxt;
  logic             wrap;
  assign link = ctl_q[0].link;

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s), .adv(adv), .modulo(mod_q),
    .count(count), .cnt_nxt(cnt_nxt), .wrap(wrap)
  );

  logic [N_CH-1:0]  out_en, cap_en, match_ev, cap_ev;
  logic [CNT_W-1:0] cmp_v [N_CH];
  always_comb begin
    out_en[0] = link || ctl_q[0].cmp;
    out_en[1] = !link && ctl_q[1].cmp;
    cap_en[0] = cap_ok && !link && !ctl_q[0].cmp;
    cap_en[1] = cap_ok && !link && !ctl_q[1].cmp;
    cmp_v[0]  = (link && sel_q) ? val_q[1] : val_q[0];
    cmp_v[1]  = val_q[1];
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk(clk), .rst_n(rst_s), .adv(adv), .wrap(wrap), .cnt_nxt(cnt_nxt),
      .cmp_val(cmp_v[c]), .out_en(out_en[c]), .tov(ctl_q[c].tov),
      .maxd(ctl_q[c].maxd), .cap_en(cap_en[c]), .rise(ctl_q[c].rise),
      .pin(pin_in[c]), .pin_out(pin_out[c]), .match_ev(match_ev[c]),
      .cap_ev(cap_ev[c])
    );
  end

  logic [N_FLAG-1:0] flag, set_v;
  assign set_v = {match_ev[1] | cap_ev[1], match_ev[0] | cap_ev[0], wrap};

  for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
    tmr_flag u_flag (
      .clk(clk), .rst_n(rst_s), .set_ev(set_v[f]),
      .rd_hit(rd_ok && (addr == flag_addr(f))),
      .wr_hit(wr_ok && (addr == flag_addr(f))),
      .wr_bit(wdata[7]), .clr_ok(clr_ok), .flag(flag[f])
    );
  end

  always_comb begin
    ovf_ie_n = ovf_ie_q;
    mod_n    = mod_q;
    ctl_n    = ctl_q;
    val_n    = val_q;
    if (wr_ok) begin
      case (addr)
        A_STAT:  ovf_ie_n = wdata[6];
        A_MOD:   mod_n    = wdata;
        A_C0CTL: ctl_n[0] = chctl_t'(wdata[6:1]);
        A_C1CTL: ctl_n[1] = chctl_t'(wdata[6:1]);
        A_C0VAL: val_n[0] = wdata;
        A_C1VAL: val_n[1] = wdata;
        default: ;
      endcase
    end
    for (int c = 0; c < N_CH; c++) if (cap_ev[c]) val_n[c] = count;
    // linked buffer: alternate only at a wrap with a pending write
    sel_n  = sel_q;
    pend_n = pend_q;
    if (!link) begin
      sel_n  = 1'b0;
      pend_n = 1'b0;
    end else begin
      if (wrap && pend_q) begin
        sel_n  = !sel_q;
        pend_n = 1'b0;
      end
      if (wr_ok && (((addr == A_C0VAL) && sel_n) || ((addr == A_C1VAL) && !sel_n)))
        pend_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ovf_ie_q <= 1'b0;
      mod_q    <= '1;
      sel_q    <= 1'b0;
      pend_q   <= 1'b0;
      for (int c = 0; c < N_CH; c++) begin
        ctl_q[c] <= '0;
        val_q[c] <= '0;
      end
    end else begin
      ovf_ie_q <= ovf_ie_n;
      mod_q    <= mod_n;
      sel_q    <= sel_n;
      pend_q   <= pend_n;
      ctl_q    <= ctl_n;
      val_q    <= val_n;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_STAT:  rdata = CNT_W'({flag[0], ovf_ie_q, 6'b0});
      A_COUNT: rdata = count;
      A_MOD:   rdata = mod_q;
      A_C0CTL: rdata = CNT_W'({flag[1], ctl_q[0], 1'b0});
      A_C0VAL: rdata = val_q[0];
      A_C1CTL: rdata = CNT_W'({flag[2], ctl_q[1], 1'b0});
      A_C1VAL: rdata = val_q[1];
      default: rdata = '0;
    endcase
    irq_ovf   = flag[0] && ovf_ie_q;
    irq_ch[0] = flag[1] && ctl_q[0].ie;
    irq_ch[1] = flag[2] && ctl_q[1].ie;
  end

  AST_SEL_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_s)
    (link && !wrap) |=> (!link || $stable(sel_q))); // R12
  AST_BRK_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_s)
    (brk && !wr_en) |=> ($stable(val_q[0]) && $stable(val_q[1]))); // R9
  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_s)
    stop_mode |=> ($stable(count) && $stable(mod_q))); // R10
  AST_LINK_PIN1_LOW: assert property (@(posedge clk) disable iff (!rst_s)
    link |=> (!link || !pin_out[1])); // R11
endmodule

// File: tb/tb_pair_timer.sv
module tb_pair_timer;
  localparam int unsigned W = 8;

  logic clk = 1'b0;
  logic rst_n, tick_en, wr_en, rd_en, brk, brk_clr_ok, stop_mode, irq_ovf;
  logic [2:0]   addr;
  logic [W-1:0] wdata, rdata;
  logic [1:0]   pin_in, pin_out, irq_ch;

  always #5 clk = ~clk;

  pair_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out),
    .brk(brk), .brk_clr_ok(brk_clr_ok), .stop_mode(stop_mode),
    .irq_ovf(irq_ovf), .irq_ch(irq_ch)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // modulo, value, set-on-overflow, full duty, expected high cycles per period
  localparam int VEC [0:5][0:4] = '{
    '{9, 3, 1, 0, 3},  '{9, 0, 1, 0, 0},  '{9, 7, 0, 0, 0},
    '{9, 5, 1, 1, 10}, '{4, 4, 1, 0, 4},  '{4, 9, 1, 0, 5}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input int d);
    @(negedge clk);
    addr = a; wdata = W'(d); wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = int'(rdata);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int v, hi, p1;
    tick_en = 0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0; pin_in = 0;
    brk = 0; brk_clr_ok = 0; stop_mode = 0;
    do_reset();

    // R1 reset state
    rd(3'd1, v); chk(v == 0, "R1 count", v, 0);
    rd(3'd2, v); chk(v == 255, "R1 modulo", v, 255);
    rd(3'd3, v); chk(v == 0, "R1 ctl0", v, 0);
    rd(3'd6, v); chk(v == 0, "R1 val1", v, 0);
    chk(pin_out == 0 && irq_ovf == 0 && irq_ch == 0, "R1 outputs", int'(pin_out), 0);

    // R4 R5 R6 duty table
    for (int i = 0; i < 6; i++) begin
      do_reset();
      wr(3'd2, VEC[i][0]);
      wr(3'd4, VEC[i][1]);
      wr(3'd3, 'h10 | (VEC[i][2] << 2) | (VEC[i][3] << 1));
      @(negedge clk); tick_en = 1'b1;
      repeat (3 * (VEC[i][0] + 1)) @(negedge clk);
      hi = 0;
      for (int k = 0; k <= VEC[i][0]; k++) begin
        @(negedge clk);
        if (pin_out[0]) hi++;
      end
      tick_en = 1'b0;
      chk(hi == VEC[i][4], "R4/R5/R6 duty vector", hi, VEC[i][4]);
    end

    // R2 counting and wrap
    do_reset();
    wr(3'd2, 2);
    ticks(1); rd(3'd1, v); chk(v == 1, "R2 count one", v, 1);
    ticks(1); rd(3'd1, v); chk(v == 2, "R2 count at modulo", v, 2);
    rd(3'd0, v); chk(v == 0, "R2 no flag before wrap", v, 0);
    ticks(1); rd(3'd1, v); chk(v == 0, "R2 wrap to zero", v, 0);
    rd(3'd0, v); chk(v == 'h80, "R2 overflow flag", v, 'h80);
    chk(irq_ovf == 1'b0, "R3 irq masked", int'(irq_ovf), 0);
    wr(3'd0, 'hC0);
    chk(irq_ovf == 1'b1, "R3 irq enabled", int'(irq_ovf), 1);

    // R8 clear sequence
    wr(3'd0, 'h40);
    rd(3'd0, v); chk(v == 'hC0, "R8 write without read keeps flag", v, 'hC0);
    wr(3'd0, 'h40);
    rd(3'd0, v); chk(v == 'h40, "R8 read then write clears", v, 'h40);
    chk(irq_ovf == 1'b0, "R3 irq drops with flag", int'(irq_ovf), 0);
    ticks(3); ticks(2);
    rd(3'd0, v);
    @(negedge clk);
    addr = 3'd0; wdata = 'h40; wr_en = 1'b1; tick_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick_en = 1'b0;
    rd(3'd0, v); chk(v == 'hC0, "R8 event wins over clear", v, 'hC0);

    // R9 break
    brk = 1'b1;
    ticks(3); rd(3'd1, v); chk(v == 0, "R9 counter halts in break", v, 0);
    rd(3'd0, v); wr(3'd0, 'h40);
    rd(3'd0, v); chk(v == 'hC0, "R9 clear blocked in break", v, 'hC0);
    brk_clr_ok = 1'b1;
    rd(3'd0, v); wr(3'd0, 'h40);
    rd(3'd0, v); chk(v == 'h40, "R9 clear allowed in break", v, 'h40);
    brk = 1'b0; brk_clr_ok = 1'b0;

    // R10 stop
    stop_mode = 1'b1;
    ticks(2); wr(3'd2, 7);
    stop_mode = 1'b0;
    rd(3'd1, v); chk(v == 0, "R10 counter frozen", v, 0);
    rd(3'd2, v); chk(v == 2, "R10 write ignored", v, 2);

    // R7 capture
    wr(3'd2, 200);
    ticks(7);
    wr(3'd5, 'h48);
    @(negedge clk); pin_in[1] = 1'b1;
    @(negedge clk);
    rd(3'd6, v); chk(v == 7, "R7 rising capture value", v, 7);
    rd(3'd5, v); chk(v == 'hC8, "R7 capture flag", v, 'hC8);
    chk(irq_ch[1] == 1'b1, "R3 channel irq", int'(irq_ch[1]), 1);
    ticks(2);
    brk = 1'b1;
    @(negedge clk); pin_in[1] = 1'b0;
    @(negedge clk); pin_in[1] = 1'b1;
    @(negedge clk);
    brk = 1'b0;
    rd(3'd6, v); chk(v == 7, "R9 capture ignored in break", v, 7);
    pin_in[1] = 1'b0;
    wr(3'd3, 'h00);
    @(negedge clk); pin_in[0] = 1'b1;
    @(negedge clk);
    rd(3'd4, v); chk(v == 0, "R7 wrong edge ignored", v, 0);
    @(negedge clk); pin_in[0] = 1'b0;
    @(negedge clk);
    rd(3'd4, v); chk(v == 9, "R7 falling capture value", v, 9);

    // R11 R12 linked buffered PWM
    do_reset();
    wr(3'd2, 9);
    wr(3'd4, 3);
    wr(3'd3, 'h24);
    @(negedge clk); tick_en = 1'b1;
    repeat (25) @(negedge clk);
    p1 = int'(pin_out[0]);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (p1 == 0 && pin_out[0]) break;
      p1 = int'(pin_out[0]);
    end
    hi = 0; v = 0;
    for (int k = 0; k < 10; k++) begin
      if (k != 0) @(negedge clk);
      if (pin_out[0]) hi++;
      if (pin_out[1]) v++;
      if (k == 1) begin addr = 3'd6; wdata = 8'd7; wr_en = 1'b1; end
      if (k == 2) wr_en = 1'b0;
    end
    chk(hi == 3, "R12 no change mid-period", hi, 3);
    chk(hi == 3, "R11 linked output uses ch0 value first", hi, 3);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (pin_out[0]) hi++;
      if (pin_out[1]) v++;
    end
    chk(hi == 7, "R12 new duty after wrap", hi, 7);
    chk(v == 0, "R11 pin_out[1] low when linked", v, 0);
    wr(3'd3, 'h26);
    repeat (12) @(negedge clk);
    hi = 0;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      if (pin_out[0]) hi++;
    end
    tick_en = 1'b0;
    chk(hi == 10, "R11 linked full duty from ch0 control", hi, 10);

    finish_run();
  end
endmodule